// File: doc/BRIEF.md
# Reference DAC Slew Sequencer

This block owns the reference code of a step-down regulator's voltage DAC. When the requested code differs from the code now driven, it waits a fixed number of microsecond ticks. It then walks the DAC code one LSB (25 mV) per slew-clock pulse until it reaches the request. After the final code is set, it holds for one more full slew-clock period before it reports the move as finished. A power-good monitor uses the `pg_mask` flag to ignore its window comparator while the reference is moving.

The slew-clock rate is set outside the block and arrives as a one-cycle `slew_tick` pulse. The pre-delay is timed from a one-cycle `us_tick` pulse that comes every microsecond. While `supply_ok` is low the block is off and drives code 0. When `supply_ok` rises, the request is sampled and the block ramps up to it. This power-up ramp and any power-down never assert `pg_mask`. A new request that arrives during a move restarts the sequence from the code now driven, with a fresh pre-delay.

Top module: `vdac_slew_seq`

## Requirements
- R1: After reset, and in every cycle after one in which `supply_ok` was low, `dac_code` is 0 and `busy` and `pg_mask` are 0. Changes on `target_code` have no effect while `supply_ok` is low.
- R2: In the cycle after `supply_ok` rises, `busy` is 1 and the sampled `target_code` becomes the destination. `pg_mask` stays 0 for the whole of this power-up ramp.
- R3: After a move starts, `dac_code` does not change until `PRE_US` (default 4) `us_tick` pulses have been seen. Slew pulses during this wait are ignored.
- R4: After the pre-delay, each `slew_tick` moves `dac_code` by exactly one code toward the destination, visible in the next cycle. `dac_code` never changes in a cycle without a slew pulse.
- R5: Once `dac_code` equals the destination, `busy` and `pg_mask` keep their values until the next `slew_tick`. Both are 0 in the cycle after that pulse.
- R6: For a move that does not start at power-up, `pg_mask` is 1 from the cycle after the request changes until the hold of R5 ends.
- R7: A request equal to the current `dac_code` while idle starts no move: `busy` and `pg_mask` stay 0 and the code is unchanged.
- R8: A request that differs from the current destination during a move restarts the pre-delay, with `pg_mask` 1, from the code now driven, toward the new request. This also applies during the power-up ramp.
- R9: When `supply_ok` falls during a move, `dac_code` goes to 0 and `busy` and `pg_mask` go to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_ok | input | 1 | Supply above its valid threshold |
| target_code | input | CODE_W | Requested DAC code |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| slew_tick | input | 1 | One-cycle pulse per slew-clock period |
| dac_code | output | CODE_W | Reference code driven to the DAC |
| busy | output | 1 | A move (including the power-up ramp) is in progress |
| pg_mask | output | 1 | Power-good masking request |

## Verification
The bench goes after slew pulses that arrive during the pre-delay. A design that counted them would move the code early. It checks the extra hold period: a design that dropped the mask on the final step would let power-good glitch while the output settles. It sends requests equal to the present code, where a faulty design would mask power-good for nothing. It retargets mid-move, where a design that jumped straight to the new value or skipped the fresh delay would show up. It also covers the full-scale 0 to 31 ramps in both directions, a power-up ramp that must never mask, and power loss during a move, which must force code 0 at once.

// File: rtl/vdac_slew_pkg.sv
package vdac_slew_pkg;
  typedef enum logic [2:0] {
    SQ_OFF  = 3'd0,
    SQ_IDLE = 3'd1,
    SQ_WAIT = 3'd2,
    SQ_RAMP = 3'd3,
    SQ_HOLD = 3'd4
  } seq_state_t;
endpackage

// File: rtl/vdac_predelay.sv
module vdac_predelay #(
  parameter int PRE_US = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en,
  input  logic us_tick,
  output logic done
);
  localparam int CW = $clog2(PRE_US + 1);
  localparam logic [CW-1:0] LAST = CW'(PRE_US - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = '0;
    else if (en && us_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = en && us_tick && (cnt_q == LAST) && !load;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= LAST));
  assert_cnt_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(en && us_tick)) |=> $stable(cnt_q));
endmodule

// File: rtl/vdac_stepper.sv
module vdac_stepper #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero,
  input  logic              step_en,
  input  logic              up,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] code_step
);
  logic [CODE_W-1:0] code_d;

  assign code_step = up ? (code_q + 1'b1) : (code_q - 1'b1);

  always_comb begin
    code_d = code_q;
    if (zero) code_d = '0;
    else if (step_en) code_d = code_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assert_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && !step_en) |=> $stable(code_q));
  assert_up_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && step_en && up) |=> (code_q == $past(code_q) + 1'b1));
  assert_dn_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && step_en && !up) |=> (code_q == $past(code_q) - 1'b1));
endmodule

// File: rtl/vdac_slew_seq.sv
module vdac_slew_seq
  import vdac_slew_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int PRE_US = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic [CODE_W-1:0] target_code,
  input  logic              us_tick,
  input  logic              slew_tick,
  output logic [CODE_W-1:0] dac_code,
  output logic              busy,
  output logic              pg_mask
);
  seq_state_t        state_q, state_d;
  logic [CODE_W-1:0] dest_q, dest_d;
  logic              pwrup_q, pwrup_d;
  logic              pre_load, pre_done, step_en, zero;
  logic [CODE_W-1:0] code_step;
  logic              running, retarget, up;

  assign running  = (state_q == SQ_WAIT) || (state_q == SQ_RAMP) || (state_q == SQ_HOLD);
  assign retarget = running && (target_code != dest_q);
  assign up       = dest_q > dac_code;

  always_comb begin
    state_d  = state_q;
    dest_d   = dest_q;
    pwrup_d  = pwrup_q;
    pre_load = 1'b0;
    step_en  = 1'b0;
    zero     = 1'b0;
    if (!supply_ok) begin
      state_d = SQ_OFF;
      pwrup_d = 1'b0;
      zero    = 1'b1;
    end else begin
      unique case (state_q)
        SQ_OFF: begin
          dest_d   = target_code;
          pwrup_d  = 1'b1;
          state_d  = SQ_WAIT;
          pre_load = 1'b1;
        end
        SQ_IDLE: begin
          if (target_code != dac_code) begin
            dest_d   = target_code;
            pwrup_d  = 1'b0;
            state_d  = SQ_WAIT;
            pre_load = 1'b1;
          end
        end
        default: begin
          if (retarget) begin
            dest_d   = target_code;
            pwrup_d  = 1'b0;
            state_d  = SQ_WAIT;
            pre_load = 1'b1;
          end else if (state_q == SQ_WAIT) begin
            if (pre_done) state_d = (dest_q == dac_code) ? SQ_HOLD : SQ_RAMP;
          end else if (state_q == SQ_RAMP) begin
            if (slew_tick) begin
              step_en = 1'b1;
              if (code_step == dest_q) state_d = SQ_HOLD;
            end
          end else if (slew_tick) begin
            state_d = SQ_IDLE;
            pwrup_d = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_OFF;
      dest_q  <= '0;
      pwrup_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dest_q  <= dest_d;
      pwrup_q <= pwrup_d;
    end
  end

  vdac_predelay #(.PRE_US(PRE_US)) u_predelay (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pre_load),
    .en      (state_q == SQ_WAIT),
    .us_tick (us_tick),
    .done    (pre_done)
  );

  vdac_stepper #(.CODE_W(CODE_W)) u_stepper (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero      (zero),
    .step_en   (step_en),
    .up        (up),
    .code_q    (dac_code),
    .code_step (code_step)
  );

  assign busy    = running;
  assign pg_mask = running && !pwrup_q;

  assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (dac_code == '0 && !busy && !pg_mask));
  assert_wait_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WAIT && supply_ok) |=> $stable(dac_code));
  assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HOLD && supply_ok && !slew_tick && !retarget) |=> (busy && $stable(pg_mask)));
  assert_equal_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && supply_ok && target_code == dac_code) |=> (!busy && !pg_mask));
  assert_pwrup_nomask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_OFF && supply_ok) |=> (busy && !pg_mask));
  assert_retarget_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retarget && supply_ok) |=> (state_q == SQ_WAIT && pg_mask && $stable(dac_code)));
endmodule

// File: tb/vdac_slew_seq_bench.sv
module vdac_slew_seq_bench;
  localparam int CODE_W = 5;
  localparam int PRE_US = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              supply_ok = 1'b0;
  logic [CODE_W-1:0] target_code = '0;
  logic              us_tick = 1'b0;
  logic              slew_tick = 1'b0;
  logic [CODE_W-1:0] dac_code;
  logic              busy;
  logic              pg_mask;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5ns clk = ~clk;

  vdac_slew_seq #(.CODE_W(CODE_W), .PRE_US(PRE_US)) u_vdac_slew_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .target_code(target_code),
    .us_tick(us_tick), .slew_tick(slew_tick), .dac_code(dac_code),
    .busy(busy), .pg_mask(pg_mask)
  );

  function automatic int toward(input int c, input int t);
    if (t > c) return c + 1;
    if (t < c) return c - 1;
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle(input bit us, input bit sl);
    @(negedge clk);
    us_tick = us;
    slew_tick = sl;
    @(posedge clk);
    #1ns;
    us_tick = 1'b0;
    slew_tick = 1'b0;
  endtask

  task automatic do_move(input int tgt, input bit pwr, input int max_steps);
    int start = int'(dac_code);
    bit mid = busy;
    bit em = !pwr;
    int exp_c;
    int steps = 0;
    target_code = CODE_W'(tgt);
    if (pwr) supply_ok = 1'b1;
    cycle(0, 0);
    if (!pwr && !mid && tgt == start) begin
      chk(busy == 1'b0, "R7 busy", busy, 0);
      chk(pg_mask == 1'b0, "R7 mask", pg_mask, 0);
      chk(int'(dac_code) == start, "R7 code", dac_code, start);
      return;
    end
    chk(busy == 1'b1, mid ? "R8 busy" : "R2/R6 busy", busy, 1);
    chk(pg_mask == em, pwr ? "R2 mask" : "R6 mask", pg_mask, em);
    chk(int'(dac_code) == start, "R8 code kept", dac_code, start);
    for (int i = 0; i < PRE_US; i++) begin
      repeat ($urandom % 3) cycle(0, 0);
      cycle(0, 1);
      chk(int'(dac_code) == start, "R3 slew ignored", dac_code, start);
      cycle(1, 0);
      chk(int'(dac_code) == start, "R3 frozen", dac_code, start);
    end
    exp_c = start;
    while (exp_c != tgt && steps < max_steps) begin
      if ($urandom % 2) begin
        cycle(0, 0);
        chk(int'(dac_code) == exp_c, "R4 no tick", dac_code, exp_c);
      end
      cycle(0, 1);
      exp_c = toward(exp_c, tgt);
      steps++;
      chk(int'(dac_code) == exp_c, "R4 step", dac_code, exp_c);
      chk(busy == 1'b1 && pg_mask == em, "R6 mask during ramp", pg_mask, em);
    end
    if (exp_c != tgt) return;
    repeat (1 + $urandom % 3) begin
      cycle(1, 0);
      chk(busy == 1'b1 && pg_mask == em, "R5 hold", pg_mask, em);
    end
    cycle(0, 1);
    chk(busy == 1'b0, "R5 busy released", busy, 0);
    chk(pg_mask == 1'b0, "R5 mask released", pg_mask, 0);
    chk(int'(dac_code) == tgt, "R5 final code", dac_code, tgt);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h0000_51E7);
    repeat (3) @(posedge clk);
    #1ns rst_n = 1'b1;
    cycle(0, 0);
    chk(dac_code == '0 && !busy && !pg_mask, "R1 reset state", dac_code, 0);
    target_code = 5'd17;
    cycle(1, 1);
    chk(dac_code == '0 && !busy, "R1 off ignores target", dac_code, 0);

    do_move(12, 1'b1, 99);
    do_move(12, 1'b0, 99);
    do_move(31, 1'b0, 99);
    do_move(0, 1'b0, 99);
    do_move(20, 1'b0, 3);
    do_move(2, 1'b0, 99);
    do_move(9, 1'b0, 2);
    do_move(4, 1'b0, 1);
    do_move(5, 1'b0, 99);

    do_move(25, 1'b0, 3);
    supply_ok = 1'b0;
    cycle(0, 1);
    chk(dac_code == '0 && !busy && !pg_mask, "R9 power loss", dac_code, 0);
    target_code = 5'd7;
    cycle(1, 1);
    chk(dac_code == '0 && !busy, "R1 held off", dac_code, 0);

    do_move(0, 1'b1, 99);
    supply_ok = 1'b0;
    cycle(0, 0);
    do_move(18, 1'b1, 2);
    do_move(10, 1'b0, 99);

    for (int k = 0; k < 40; k++) begin
      int t1 = $urandom % 32;
      if ($urandom % 4 == 0) begin
        int t2 = $urandom % 32;
        do_move(t1, 1'b0, $urandom % 4);
        if (busy && t2 == t1) t2 = (t1 + 1) % 32;
        do_move(t2, 1'b0, 99);
      end else begin
        do_move(t1, 1'b0, 99);
      end
      repeat ($urandom % 3) cycle(0, 0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule